// File: doc/BRIEF.md
# Flash Command and Bus Interface

This block models the control side of a byte-wide flash memory as synchronous logic. The chip-level control pins are the power-down/reset pin, chip enable, output enable and write enable. They are registered on the system clock together with the address, the write data, a low-supply lockout input and a high-programming-voltage flag. The registered pins drive a read-path truth table and a write-strobe detector. A write strobe is taken on the falling edge of the sampled write enable while the chip is selected and its outputs are off.

A command state machine receives the strobes. It selects one of three read views: array bytes, fixed identifier codes, or a status byte. It also accepts two-strobe programme and block-erase sequences. An accepted operation starts a cycle counter that stands in for the internal algorithm. While the counter runs, the ready/busy output is low. When the counter finishes, the small on-chip array is updated. Programming clears bits only, and an erase sets a whole block to ones. Deselecting the chip does not stop an operation. Pulling the power-down pin low, or raising lockout, stops everything.

Top module: `flash_cmd_if`

## Requirements
- R1: `dout_oe` is 1 only when the sampled pins show power-down high, chip enable low, output enable low, write enable high and lockout low. Whenever `dout_oe` is 0, `dout` is 0.
- R2: After system reset, and after the power-down pin returns high, the read view is the array: a read returns the stored byte, and every byte reads 0xFF after system reset.
- R3: Command 0x90 selects the identifier view. It returns 0x89 when addr[0]=0 and 0xA1 when addr[0]=1.
- R4: Command 0x70 selects the status view. The status byte is {ready, 0, erase-error, write-error, vpp-error, 0, 0, 0}, with bit 7 the ready flag and bits 5, 4 and 3 the error flags.
- R5: Command 0x40 followed by a second strobe carrying address and data programs that byte with (old AND data). The change is visible once ready returns. The read view changes to status.
- R6: Command 0x20 followed by 0xD0 sets to 0xFF every byte of the block that holds the confirm address. The block is selected by the upper address bits, and bytes in other blocks are unchanged.
- R7: An erase confirm other than 0xD0 sets the erase-error bit, leaves the array unchanged, and leaves the status view selected.
- R8: If the programming-voltage flag is low at the second strobe, nothing is changed. The vpp-error bit is set together with write-error (for a programme) or erase-error (for an erase).
- R9: `ry_by` is low for exactly WR_CYCLES cycles after a programme starts, and for ER_CYCLES cycles after an erase starts. It is high when the block is idle.
- R10: Holding chip enable high during an operation does not stop it.
- R11: Power-down low releases the outputs, forces `ry_by` high, aborts a running operation without changing the array, clears the error bits, and ignores all writes.
- R12: Lockout high releases the outputs and ignores all writes.
- R13: Command 0x50 clears the three error bits.
- R14: A strobe whose data is not a command leaves both the array and the read view unchanged. Strobes that arrive while the block is busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| rp_n | input | 1 | Power-down/reset pin, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| lockout | input | 1 | Low-supply lockout, active high |
| vpp_hi | input | 1 | Programming voltage present |
| addr | input | AW | Byte address |
| din | input | 8 | Write data / command byte |
| dout | output | 8 | Read data, zero when released |
| dout_oe | output | 1 | Data output enable |
| ry_by | output | 1 | Ready (1) / busy (0) |

## Verification
The hardest state to reach from the ports is power-down arriving in the middle of an operation. Two of its effects need their own proof: the array must not be changed, and the read view must return to the array. The bench starts a programme of a byte that is still erased. It pulls power-down low two cycles later, issues an identifier command that must be ignored, and releases the pin. It then reads that byte at an even address. Any value other than 0xFF shows either a stray commit (0x00) or a stale view (0x89). Ignored strobes during an erase are exercised in the same way. An identifier command is sent while busy, and the status byte is read after ready returns.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   localparam int DW = 8;

   typedef enum logic [1:0] {
      RM_ARRAY  = 2'd0,
      RM_IDENT  = 2'd1,
      RM_STATUS = 2'd2
   } rmode_t;

   typedef enum logic [1:0] {
      FS_IDLE   = 2'd0,
      FS_WR_ARM = 2'd1,
      FS_ER_ARM = 2'd2,
      FS_BUSY   = 2'd3
   } fsm_t;

   localparam logic [DW-1:0] CMD_RD_ARRAY  = 8'hFF;
   localparam logic [DW-1:0] CMD_RD_IDENT  = 8'h90;
   localparam logic [DW-1:0] CMD_RD_STATUS = 8'h70;
   localparam logic [DW-1:0] CMD_CLR_STAT  = 8'h50;
   localparam logic [DW-1:0] CMD_PROG      = 8'h40;
   localparam logic [DW-1:0] CMD_ERASE     = 8'h20;
   localparam logic [DW-1:0] CMD_CONFIRM   = 8'hD0;

   localparam logic [DW-1:0] ID_MAKER  = 8'h89;
   localparam logic [DW-1:0] ID_DEVICE = 8'hA1;

   localparam int SB_READY = 7;
   localparam int SB_ERERR = 5;
   localparam int SB_WRERR = 4;
   localparam int SB_VPERR = 3;

endpackage

// File: rtl/flash_pin_sync.sv
module flash_pin_sync #(
   parameter int AW          = 6,
   parameter int SYNC_STAGES = 1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           rp_n,
   input  logic                           ce_n,
   input  logic                           oe_n,
   input  logic                           we_n,
   input  logic                           lockout,
   input  logic                           vpp_hi,
   input  logic [AW-1:0]                  addr,
   input  logic [flash_cmd_pkg::DW-1:0]   din,
   output logic                           s_rp_n,
   output logic                           s_vpp,
   output logic [AW-1:0]                  s_addr,
   output logic [flash_cmd_pkg::DW-1:0]   s_din,
   output logic                           active,
   output logic                           rd_en,
   output logic                           wr_stb
);
   localparam int DW = flash_cmd_pkg::DW;
   localparam int PW = 6 + AW + DW;
   localparam logic [PW-1:0] IDLE_VEC = {1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, {AW{1'b0}}, {DW{1'b0}}};

   if (SYNC_STAGES < 1 || SYNC_STAGES > 2) begin : g_bad_stages
      $error("SYNC_STAGES must be 1 or 2");
   end

   logic [PW-1:0] pipe [SYNC_STAGES];
   logic [PW-1:0] raw;
   logic          s_ce_n, s_oe_n, s_we_n, s_lock;
   logic          we_prev;

   assign raw = {rp_n, ce_n, oe_n, we_n, lockout, vpp_hi, addr, din};

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[0] <= IDLE_VEC;
            else        pipe[0] <= raw;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= IDLE_VEC;
            else        pipe[s] <= pipe[s-1];
         end
      end
   end

   assign {s_rp_n, s_ce_n, s_oe_n, s_we_n, s_lock, s_vpp, s_addr, s_din} = pipe[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) we_prev <= 1'b1;
      else        we_prev <= s_we_n;
   end

   assign active = s_rp_n && !s_lock;
   assign rd_en  = active && !s_ce_n && !s_oe_n && s_we_n;
   assign wr_stb = active && !s_ce_n && s_oe_n && !s_we_n && we_prev;

endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
   parameter int WR_CYCLES = 8,
   parameter int ER_CYCLES = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic abort,
   input  logic start,
   input  logic is_erase,
   output logic busy,
   output logic done
);
   localparam int MAXC = (WR_CYCLES > ER_CYCLES) ? WR_CYCLES : ER_CYCLES;
   localparam int CW   = $clog2(MAXC + 1);
   localparam logic [CW-1:0] WR_LOAD = CW'(WR_CYCLES);
   localparam logic [CW-1:0] ER_LOAD = CW'(ER_CYCLES);

   if (WR_CYCLES < 1 || ER_CYCLES < 1) begin : g_bad_len
      $error("busy lengths must be at least one cycle");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (abort)          cnt <= '0;
      else if (start)          cnt <= is_erase ? ER_LOAD : WR_LOAD;
      else if (cnt != '0)      cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);
   assign done = (cnt == CW'(1)) && !abort;

endmodule

// File: rtl/flash_store.sv
module flash_store #(
   parameter int AW       = 6,
   parameter int BLOCKS   = 4,
   parameter bit PROG_AND = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          prog_en,
   input  logic                          erase_en,
   input  logic [AW-1:0]                 waddr,
   input  logic [flash_cmd_pkg::DW-1:0]  wdata,
   input  logic [AW-1:0]                 raddr,
   output logic [flash_cmd_pkg::DW-1:0]  rdata
);
   localparam int DW        = flash_cmd_pkg::DW;
   localparam int DEPTH     = 1 << AW;
   localparam int BBITS     = $clog2(BLOCKS);
   localparam int BLK_WORDS = DEPTH / BLOCKS;

   if (BLOCKS < 2 || (1 << BBITS) != BLOCKS || BLOCKS > DEPTH) begin : g_bad_blocks
      $error("BLOCKS must be a power of two between 2 and the depth");
   end

   logic [DW-1:0]    mem [DEPTH];
   logic [DW-1:0]    prog_val;
   logic [BBITS-1:0] wblk;
   logic [BLOCKS-1:0] hit;

   assign wblk = waddr[AW-1 -: BBITS];

   for (genvar b = 0; b < BLOCKS; b++) begin : g_blk
      assign hit[b] = erase_en && (wblk == BBITS'(b));
   end

   if (PROG_AND) begin : g_and
      assign prog_val = mem[waddr] & wdata;
   end else begin : g_over
      assign prog_val = wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (hit[i / BLK_WORDS]) mem[i] <= '1;
         end
         if (prog_en) mem[waddr] <= prog_val;
      end
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm #(
   parameter int AW = 6
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          active,
   input  logic                          pd,
   input  logic                          wr_stb,
   input  logic                          vpp_ok,
   input  logic [AW-1:0]                 s_addr,
   input  logic [flash_cmd_pkg::DW-1:0]  s_din,
   input  logic                          tmr_busy,
   input  logic                          tmr_done,
   output flash_cmd_pkg::rmode_t         rmode,
   output logic                          start,
   output logic                          start_erase,
   output logic                          commit_prog,
   output logic                          commit_erase,
   output logic [AW-1:0]                 op_addr,
   output logic [flash_cmd_pkg::DW-1:0]  op_data,
   output logic [flash_cmd_pkg::DW-1:0]  status
);
   import flash_cmd_pkg::*;

   fsm_t st;
   logic op_erase;
   logic er_err, wr_err, vp_err;
   logic is_confirm;

   assign is_confirm  = (s_din == CMD_CONFIRM);
   assign start_erase = (st == FS_ER_ARM);
   assign start       = active && wr_stb && vpp_ok &&
                        ((st == FS_WR_ARM) || (st == FS_ER_ARM && is_confirm));
   assign commit_prog  = tmr_done && (st == FS_BUSY) && !op_erase;
   assign commit_erase = tmr_done && (st == FS_BUSY) &&  op_erase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= FS_IDLE;
         rmode    <= RM_ARRAY;
         op_erase <= 1'b0;
         op_addr  <= '0;
         op_data  <= '0;
         er_err   <= 1'b0;
         wr_err   <= 1'b0;
         vp_err   <= 1'b0;
      end else if (!active) begin
         st <= FS_IDLE;
         if (pd) begin
            rmode  <= RM_ARRAY;
            er_err <= 1'b0;
            wr_err <= 1'b0;
            vp_err <= 1'b0;
         end
      end else begin
         unique case (st)
            FS_IDLE: if (wr_stb) begin
               case (s_din)
                  CMD_RD_ARRAY:  rmode <= RM_ARRAY;
                  CMD_RD_IDENT:  rmode <= RM_IDENT;
                  CMD_RD_STATUS: rmode <= RM_STATUS;
                  CMD_CLR_STAT: begin
                     er_err <= 1'b0;
                     wr_err <= 1'b0;
                     vp_err <= 1'b0;
                  end
                  CMD_PROG: begin
                     st    <= FS_WR_ARM;
                     rmode <= RM_STATUS;
                  end
                  CMD_ERASE: begin
                     st    <= FS_ER_ARM;
                     rmode <= RM_STATUS;
                  end
                  default: ;
               endcase
            end
            FS_WR_ARM: if (wr_stb) begin
               op_addr  <= s_addr;
               op_data  <= s_din;
               op_erase <= 1'b0;
               if (vpp_ok) begin
                  st <= FS_BUSY;
               end else begin
                  st     <= FS_IDLE;
                  wr_err <= 1'b1;
                  vp_err <= 1'b1;
               end
            end
            FS_ER_ARM: if (wr_stb) begin
               op_addr  <= s_addr;
               op_erase <= 1'b1;
               if (!is_confirm) begin
                  st     <= FS_IDLE;
                  er_err <= 1'b1;
               end else if (vpp_ok) begin
                  st <= FS_BUSY;
               end else begin
                  st     <= FS_IDLE;
                  er_err <= 1'b1;
                  vp_err <= 1'b1;
               end
            end
            FS_BUSY: if (tmr_done) st <= FS_IDLE;
            default: st <= FS_IDLE;
         endcase
      end
   end

   always_comb begin
      status           = '0;
      status[SB_READY] = !tmr_busy;
      status[SB_ERERR] = er_err;
      status[SB_WRERR] = wr_err;
      status[SB_VPERR] = vp_err;
   end

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if #(
   parameter int AW          = 6,
   parameter int BLOCKS      = 4,
   parameter int WR_CYCLES   = 8,
   parameter int ER_CYCLES   = 20,
   parameter int SYNC_STAGES = 1,
   parameter bit PROG_AND    = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rp_n,
   input  logic          ce_n,
   input  logic          oe_n,
   input  logic          we_n,
   input  logic          lockout,
   input  logic          vpp_hi,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    din,
   output logic [7:0]    dout,
   output logic          dout_oe,
   output logic          ry_by
);
   import flash_cmd_pkg::*;

   logic          s_rp_n, s_vpp, pin_active, rd_en, wr_stb;
   logic [AW-1:0] s_addr, op_addr;
   logic [DW-1:0] s_din, op_data, status, rdata;
   logic          start, start_erase, commit_prog, commit_erase;
   logic          tmr_busy, tmr_done;
   rmode_t        rmode;
   logic [DW-1:0] view;

   flash_pin_sync #(.AW(AW), .SYNC_STAGES(SYNC_STAGES)) u_pins (
      .clk(clk), .rst_n(rst_n), .rp_n(rp_n), .ce_n(ce_n), .oe_n(oe_n),
      .we_n(we_n), .lockout(lockout), .vpp_hi(vpp_hi), .addr(addr), .din(din),
      .s_rp_n(s_rp_n), .s_vpp(s_vpp), .s_addr(s_addr), .s_din(s_din),
      .active(pin_active), .rd_en(rd_en), .wr_stb(wr_stb)
   );

   flash_cmd_fsm #(.AW(AW)) u_fsm (
      .clk(clk), .rst_n(rst_n), .active(pin_active), .pd(!s_rp_n),
      .wr_stb(wr_stb), .vpp_ok(s_vpp), .s_addr(s_addr), .s_din(s_din),
      .tmr_busy(tmr_busy), .tmr_done(tmr_done), .rmode(rmode),
      .start(start), .start_erase(start_erase), .commit_prog(commit_prog),
      .commit_erase(commit_erase), .op_addr(op_addr), .op_data(op_data),
      .status(status)
   );

   flash_busy_timer #(.WR_CYCLES(WR_CYCLES), .ER_CYCLES(ER_CYCLES)) u_tmr (
      .clk(clk), .rst_n(rst_n), .abort(!pin_active), .start(start),
      .is_erase(start_erase), .busy(tmr_busy), .done(tmr_done)
   );

   flash_store #(.AW(AW), .BLOCKS(BLOCKS), .PROG_AND(PROG_AND)) u_store (
      .clk(clk), .rst_n(rst_n), .prog_en(commit_prog), .erase_en(commit_erase),
      .waddr(op_addr), .wdata(op_data), .raddr(s_addr), .rdata(rdata)
   );

   always_comb begin
      unique case (rmode)
         RM_IDENT:  view = s_addr[0] ? ID_DEVICE : ID_MAKER;
         RM_STATUS: view = status;
         default:   view = rdata;
      endcase
   end

   assign dout_oe = rd_en;
   assign dout    = rd_en ? view : '0;
   assign ry_by   = !tmr_busy;

endmodule

module flash_cmd_if_chk #(
   parameter int ST = 1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  rp_n,
   input logic                  ce_n,
   input logic                  oe_n,
   input logic                  we_n,
   input logic                  lockout,
   input logic [7:0]            dout,
   input logic                  dout_oe,
   input logic                  ry_by,
   input logic                  pin_rp,
   input logic                  pin_active,
   input flash_cmd_pkg::rmode_t rmode
);
   import flash_cmd_pkg::*;

   // R1
   oe_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dout_oe |-> ($past(rp_n, ST) && !$past(ce_n, ST) && !$past(oe_n, ST) &&
                   $past(we_n, ST) && !$past(lockout, ST)));

   // R1
   released_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_oe |-> (dout == 8'h00));

   // R3
   ident_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_oe && rmode == RM_IDENT) |-> (dout == 8'h89 || dout == 8'hA1));

   // R4
   status_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_oe && rmode == RM_STATUS) |-> (dout[7] == ry_by && !dout[6] && dout[2:0] == 3'b000));

   // R11
   pd_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_rp |=> ry_by);

   // R14
   busy_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ry_by && pin_active) |=> $stable(rmode));

endmodule

bind flash_cmd_if flash_cmd_if_chk #(.ST(SYNC_STAGES)) u_chk (
   .clk(clk), .rst_n(rst_n), .rp_n(rp_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
   .lockout(lockout), .dout(dout), .dout_oe(dout_oe), .ry_by(ry_by),
   .pin_rp(s_rp_n), .pin_active(pin_active), .rmode(rmode)
);

// File: tb/flash_cmd_if_test.sv
module flash_cmd_if_test;
   localparam int AW = 6;
   localparam int WRC = 8;
   localparam int ERC = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rp_n = 1'b1, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, lockout = 1'b0, vpp_hi = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [7:0] din = '0;
   logic [7:0] dout;
   logic dout_oe, ry_by;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   flash_cmd_if #(.AW(AW), .BLOCKS(4), .WR_CYCLES(WRC), .ER_CYCLES(ERC),
                  .SYNC_STAGES(1), .PROG_AND(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .rp_n(rp_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .lockout(lockout), .vpp_hi(vpp_hi), .addr(addr), .din(din),
      .dout(dout), .dout_oe(dout_oe), .ry_by(ry_by)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; din = d; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
      @(negedge clk);
      we_n = 1'b1;
      @(negedge clk);
      ce_n = 1'b1;
   endtask

   task automatic bus_read(input logic [AW-1:0] a, output logic [7:0] d, output logic oe);
      @(negedge clk);
      addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
      @(negedge clk);
      d = dout; oe = dout_oe;
      ce_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic busy_len(output int n);
      n = 0;
      while (!ry_by && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset;
      logic [7:0] d; logic oe;
      chk("R9 idle ready", ry_by, 1);
      bus_read(6'd5, d, oe);
      chk("R2 reset array", d, 8'hFF);
      chk("R1 read enable", oe, 1);
   endtask

   task automatic t_truth;
      @(negedge clk); ce_n = 0; oe_n = 1; we_n = 1;
      @(negedge clk); chk("R1 oe high", {dout_oe, dout}, 0);
      ce_n = 1; oe_n = 0;
      @(negedge clk); chk("R1 ce high", {dout_oe, dout}, 0);
      ce_n = 0; oe_n = 0; we_n = 0;
      @(negedge clk); chk("R1 we low", {dout_oe, dout}, 0);
      ce_n = 1; oe_n = 1; we_n = 1;
      @(negedge clk);
   endtask

   task automatic t_ident;
      logic [7:0] d; logic oe;
      bus_write(0, 8'h90);
      bus_read(6'd0, d, oe); chk("R3 maker", d, 8'h89);
      bus_read(6'd1, d, oe); chk("R3 device", d, 8'hA1);
   endtask

   task automatic t_prog;
      logic [7:0] d; logic oe; int n;
      bus_write(0, 8'h40);
      bus_write(6'd3, 8'hA5);
      busy_len(n); chk("R9 write busy length", n, WRC);
      bus_read(6'd3, d, oe); chk("R4 status after write", d, 8'h80);
      bus_write(0, 8'hFF);
      bus_read(6'd3, d, oe); chk("R5 programmed", d, 8'hA5);
      bus_write(0, 8'h40);
      bus_write(6'd3, 8'h3C);
      busy_len(n);
      bus_write(0, 8'hFF);
      bus_read(6'd3, d, oe); chk("R5 and-program", d, 8'h24);
   endtask

   task automatic t_erase;
      logic [7:0] d; logic oe; int n;
      bus_write(0, 8'h40); bus_write(6'd20, 8'h00); busy_len(n);
      bus_write(0, 8'h40); bus_write(6'd40, 8'h11); busy_len(n);
      bus_write(0, 8'h20); bus_write(6'd17, 8'hD0);
      busy_len(n); chk("R9 erase busy length", n, ERC);
      bus_write(0, 8'hFF);
      bus_read(6'd20, d, oe); chk("R6 block erased", d, 8'hFF);
      bus_read(6'd40, d, oe); chk("R6 other block kept", d, 8'h11);
      bus_read(6'd3, d, oe);  chk("R6 block0 kept", d, 8'h24);
   endtask

   task automatic t_bad_confirm;
      logic [7:0] d; logic oe;
      bus_write(0, 8'h20); bus_write(6'd40, 8'h33);
      bus_read(6'd40, d, oe); chk("R7 erase error status", d, 8'hA0);
      bus_write(0, 8'hFF);
      bus_read(6'd40, d, oe); chk("R7 array unchanged", d, 8'h11);
      bus_write(0, 8'h50); bus_write(0, 8'h70);
      bus_read(6'd0, d, oe); chk("R13 cleared", d, 8'h80);
   endtask

   task automatic t_vpp;
      logic [7:0] d; logic oe;
      vpp_hi = 0;
      bus_write(0, 8'h40); bus_write(6'd40, 8'h00);
      chk("R8 no busy", ry_by, 1);
      bus_read(6'd0, d, oe); chk("R8 write vpp status", d, 8'h98);
      bus_write(0, 8'h50);
      bus_write(0, 8'h20); bus_write(6'd40, 8'hD0);
      bus_read(6'd0, d, oe); chk("R8 erase vpp status", d, 8'hA8);
      bus_write(0, 8'h50);
      vpp_hi = 1;
      bus_write(0, 8'hFF);
      bus_read(6'd40, d, oe); chk("R8 array unchanged", d, 8'h11);
   endtask

   task automatic t_deselect;
      logic [7:0] d; logic oe; int n;
      bus_write(0, 8'h40); bus_write(6'd41, 8'h0F);
      chk("R10 ce high busy", {ce_n, ry_by}, 2'b10);
      busy_len(n); chk("R10 full length", n, WRC);
      bus_write(0, 8'hFF);
      bus_read(6'd41, d, oe); chk("R10 completed", d, 8'h0F);
   endtask

   task automatic t_ignored;
      logic [7:0] d; logic oe; int n;
      bus_write(6'd42, 8'h12);
      bus_read(6'd42, d, oe); chk("R14 stray write", d, 8'hFF);
      bus_write(0, 8'h20); bus_write(6'd48, 8'hD0);
      bus_write(0, 8'h90);
      busy_len(n);
      bus_read(6'd1, d, oe); chk("R14 busy command ignored", d, 8'h80);
   endtask

   task automatic t_powerdown;
      logic [7:0] d; logic oe; int n;
      bus_write(0, 8'h40); bus_write(6'd50, 8'h00);
      chk("R9 busy", ry_by, 0);
      rp_n = 0;
      @(negedge clk); @(negedge clk);
      chk("R11 ready in power-down", ry_by, 1);
      bus_read(6'd50, d, oe); chk("R11 released", {oe, d}, 0);
      bus_write(0, 8'h90);
      rp_n = 1;
      @(negedge clk); @(negedge clk);
      bus_read(6'd50, d, oe); chk("R11 abort no change, R2 array view", d, 8'hFF);
      busy_len(n); chk("R11 no restart", n, 0);
   endtask

   task automatic t_lockout;
      logic [7:0] d; logic oe;
      lockout = 1;
      @(negedge clk);
      bus_read(6'd5, d, oe); chk("R12 released", {oe, d}, 0);
      bus_write(0, 8'h90);
      lockout = 0;
      @(negedge clk);
      bus_read(6'd5, d, oe); chk("R12 command ignored", d, 8'hFF);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_truth();
      t_ident();
      bus_write(0, 8'hFF);
      t_prog();
      t_erase();
      t_bad_confirm();
      t_vpp();
      t_deselect();
      t_ignored();
      bus_write(0, 8'hFF);
      t_powerdown();
      t_lockout();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule